// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the exception-control slice of a system-control coprocessor in a 32-bit processor core. It owns the Status and Cause registers and the three saved-PC registers: one for general exceptions, one for error-class events (non-maskable interrupt and soft reset) and one for debug entry. The pipeline presents an exception request together with the PC of the faulting instruction and a flag that says whether that instruction sits in a branch delay slot. One clock edge later the block has updated its registers and drives a one-cycle redirect pulse carrying the vector address.

The block also gates the hardware interrupt lines against the Status mask and mode bits. It takes a permitted interrupt as a general exception with code 0 and executes the two return operations: return-from-exception and return-from-debug. Instruction decode, address translation and pipeline flush live elsewhere. They reach this block as single-cycle request pins and leave it through the redirect, delay-slot-acknowledge and link-clear pulses. A status-write strobe models the software write of Status.

When two requests arrive in the same cycle only one is served. An exception request comes first, then return-from-debug, then return-from-exception, then a pending interrupt, and the status write comes last.

Top module: `trapseq_top`

## Requirements
- R1: While rst_n is low and right after it rises, status_q is 0x00400004 (bit 22 boot-vector select BEV and bit 2 error level ERL set), cause_q is 0, debug_mode is 0, redirect is 0 and redirect_pc is 0xBFC00000.
- R2: irq_take is 1 exactly when (status_q[15:8] AND cause_q[15:8]) is nonzero, status_q[0] (IE) is 1, status_q[1] (EXL) is 0, status_q[2] (ERL) is 0 and debug_mode is 0. An idle cycle with irq_take high performs a general entry with exception code 0. cause_q[15:8] holds irq_lines as registered on the previous edge.
- R3: A general entry (exc_kind 0, kind 1, kinds 5 to 7, or an interrupt) taken with EXL clear writes epc_q = pc_in − 4 and cause_q[31] (BD) = 1 when in_delay_slot is 1. Otherwise it writes epc_q = pc_in and BD = 0. In both cases it sets EXL.
- R4: A general entry taken with EXL already set leaves epc_q and BD unchanged and does not pulse ds_ack.
- R5: A general vector is base + 0x180, where base is 0xBFC00200 when status_q[22] is set and 0x80000000 when it is clear.
- R6: A refill request (exc_kind 1) uses offset 0x000 when EXL is clear at entry and offset 0x180 when EXL is set.
- R7: A general entry writes its 5-bit code (exc_code, or 0 for an interrupt) into cause_q[6:2] and leaves all other Cause bits as they were.
- R8: exc_kind 2 (NMI) ORs status bit 19 into Status, and exc_kind 3 (soft reset) ORs status bit 20 into Status. Both set ERL and BEV, keep all other Status bits, save errorepc_q by the delay-slot rule of R3 and vector to 0xBFC00000.
- R9: exc_kind 4 (debug) saves depc_q by the delay-slot rule, sets debug_mode and vectors to 0xBFC00480.
- R10: A return-from-exception (eret) with ERL set redirects to errorepc_q and clears ERL. Otherwise it redirects to epc_q and clears EXL. Both cases pulse ll_clear.
- R11: A return-from-debug (deret) redirects to depc_q, clears debug_mode and pulses ll_clear.
- R12: ds_ack pulses together with redirect whenever an entry saved a PC from a delay-slot instruction (in_delay_slot = 1). This covers every error-class and debug entry and every general entry taken with EXL clear.
- R13: Priority is exception request, then deret, then eret, then interrupt, then status write (sts_wr, which applies mask 0xF878FF17). A lower-priority request in the same cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_in | input | AW | PC of the instruction being excepted |
| in_delay_slot | input | 1 | That instruction sits in a branch delay slot |
| exc_valid | input | 1 | Exception request this cycle |
| exc_kind | input | 3 | 0 general, 1 refill, 2 NMI, 3 soft reset, 4 debug |
| exc_code | input | 5 | Exception code for general and refill entries |
| irq_lines | input | IRQ_W | Hardware interrupt request lines |
| eret | input | 1 | Return-from-exception request |
| deret | input | 1 | Return-from-debug request |
| sts_wr | input | 1 | Software write of Status |
| sts_wdata | input | 32 | Data for the Status write |
| irq_take | output | 1 | An interrupt is pending and permitted |
| redirect | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | AW | Redirect target address |
| ds_ack | output | 1 | Pipeline must drop its delay-slot flag |
| ll_clear | output | 1 | Clear the load-linked flag |
| status_q | output | 32 | Status register |
| cause_q | output | 32 | Cause register |
| epc_q | output | AW | General exception saved PC |
| errorepc_q | output | AW | Error-class saved PC |
| depc_q | output | AW | Debug saved PC |
| debug_mode | output | 1 | Core is in debug mode |

## Verification
The checker watches, on every cycle, the interrupt gate against Status, Cause and debug mode, and the preservation of the saved PC and BD under a nested general exception. It also watches the Status bits that error-class entry must set, debug entry and its vector, the error-level branch of return-from-exception, and that ds_ack never fires without a redirect. Only the bench scenarios can show the exact vector for each combination of BEV, EXL and refill, and the PC−4 arithmetic. The same holds for the interrupt latency through the registered Cause pending bits, the suppression of the interrupt while in debug mode, and which of several simultaneous requests wins.

// File: rtl/trapseq_pkg.sv
// Shared encodings for the exception sequencer: register bit positions,
// fixed vector addresses, request kinds and the internal operation code.
package trapseq_pkg;

    localparam int ST_IE    = 0;
    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_IM_LO = 8;
    localparam int ST_NMI   = 19;
    localparam int ST_SR    = 20;
    localparam int ST_BEV   = 22;

    localparam int CA_BD      = 31;
    localparam int CA_IP_LO   = 8;
    localparam int CA_CODE_LO = 2;
    localparam int CODE_W     = 5;

    localparam logic [31:0] VEC_RESET    = 32'hBFC0_0000;
    localparam logic [31:0] VEC_BOOT_GEN = 32'hBFC0_0200;
    localparam logic [31:0] VEC_RUN_GEN  = 32'h8000_0000;
    localparam logic [31:0] VEC_DEBUG    = 32'hBFC0_0480;
    localparam logic [31:0] OFF_GENERAL  = 32'h0000_0180;
    localparam logic [31:0] STATUS_COLD  = (32'h1 << ST_BEV) | (32'h1 << ST_ERL);
    localparam logic [31:0] STATUS_WMASK = 32'hF878_FF17;

    typedef enum logic [2:0] {
        EK_GENERAL = 3'd0,
        EK_REFILL  = 3'd1,
        EK_NMI     = 3'd2,
        EK_SOFTRST = 3'd3,
        EK_DEBUG   = 3'd4
    } exc_kind_e;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_EXC   = 3'd1,
        OP_DERET = 3'd2,
        OP_ERET  = 3'd3,
        OP_IRQ   = 3'd4,
        OP_STSWR = 3'd5
    } op_e;

endpackage

// File: rtl/trapseq_arbiter.sv
// Picks the single operation served this cycle and gates the interrupt.
// Assumes requests are one-cycle strobes sampled at the next clock edge.
module trapseq_arbiter
    import trapseq_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             exc_valid,
    input  logic             eret,
    input  logic             deret,
    input  logic             sts_wr,
    input  logic [IRQ_W-1:0] im,
    input  logic [IRQ_W-1:0] ip,
    input  logic             ie,
    input  logic             exl,
    input  logic             erl,
    input  logic             dbg,
    output logic             irq_take,
    output op_e              op
);

    // Interrupt permitted: masked pending line and all mode gates open.
    always_comb begin
        irq_take = (|(im & ip)) && ie && !exl && !erl && !dbg;
    end

    // Fixed priority: exception, debug return, return, interrupt, write.
    always_comb begin
        if (exc_valid)     op = OP_EXC;
        else if (deret)    op = OP_DERET;
        else if (eret)     op = OP_ERET;
        else if (irq_take) op = OP_IRQ;
        else if (sts_wr)   op = OP_STSWR;
        else               op = OP_NONE;
    end

endmodule

// File: rtl/trapseq_target.sv
// Computes the redirect address, the PC to save (delay-slot rule) and
// whether the delay-slot flag is consumed. Purely combinational.
module trapseq_target
    import trapseq_pkg::*;
#(
    parameter int AW = 32
) (
    input  op_e           op,
    input  exc_kind_e     kind,
    input  logic          exl,
    input  logic          erl,
    input  logic          bev,
    input  logic          ds,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] epc,
    input  logic [AW-1:0] errorepc,
    input  logic [AW-1:0] depc,
    output logic [AW-1:0] target,
    output logic [AW-1:0] resume_pc,
    output logic          gen_entry,
    output logic          ds_taken
);

    logic [AW-1:0] gen_base;
    logic          err_class;

    // Saved PC points back at the branch when the victim is in its slot.
    always_comb begin
        resume_pc = ds ? (pc - AW'(4)) : pc;
    end

    // Classify the entry: error-class and debug versus general.
    always_comb begin
        err_class = (op == OP_EXC) &&
                    (kind == EK_NMI || kind == EK_SOFTRST || kind == EK_DEBUG);
        gen_entry = (op == OP_IRQ) || ((op == OP_EXC) && !err_class);
        ds_taken  = ds && (err_class || (gen_entry && !exl));
        gen_base  = bev ? AW'(VEC_BOOT_GEN) : AW'(VEC_RUN_GEN);
    end

    // Redirect target for every operation that changes the PC.
    always_comb begin
        unique case (op)
            OP_EXC: begin
                unique case (kind)
                    EK_REFILL:             target = gen_base + (exl ? AW'(OFF_GENERAL) : '0);
                    EK_NMI, EK_SOFTRST:    target = AW'(VEC_RESET);
                    EK_DEBUG:              target = AW'(VEC_DEBUG);
                    default:               target = gen_base + AW'(OFF_GENERAL);
                endcase
            end
            OP_IRQ:   target = gen_base + AW'(OFF_GENERAL);
            OP_ERET:  target = erl ? errorepc : epc;
            OP_DERET: target = depc;
            default:  target = '0;
        endcase
    end

endmodule

// File: rtl/trapseq_state.sv
// Holds Status, Cause, the three saved PCs, the debug flag and the
// one-cycle output pulses. Applies the operation chosen by the arbiter.
module trapseq_state
    import trapseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IRQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  exc_kind_e         kind,
    input  logic [CODE_W-1:0] code,
    input  logic [IRQ_W-1:0]  irq_lines,
    input  logic [31:0]       sts_wdata,
    input  logic [AW-1:0]     target,
    input  logic [AW-1:0]     resume_pc,
    input  logic              gen_entry,
    input  logic              ds_taken,
    input  logic              ds,
    output logic [31:0]       status_q,
    output logic [31:0]       cause_q,
    output logic [AW-1:0]     epc_q,
    output logic [AW-1:0]     errorepc_q,
    output logic [AW-1:0]     depc_q,
    output logic              debug_mode,
    output logic              redirect,
    output logic [AW-1:0]     redirect_pc,
    output logic              ds_ack,
    output logic              ll_clear
);

    // Register update: cold reset, then one operation per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q    <= STATUS_COLD;
            cause_q     <= '0;
            epc_q       <= '0;
            errorepc_q  <= '0;
            depc_q      <= '0;
            debug_mode  <= 1'b0;
            redirect    <= 1'b0;
            redirect_pc <= AW'(VEC_RESET);
            ds_ack      <= 1'b0;
            ll_clear    <= 1'b0;
        end else begin
            redirect <= 1'b0;
            ds_ack   <= 1'b0;
            ll_clear <= 1'b0;
            cause_q[CA_IP_LO +: IRQ_W] <= irq_lines;
            unique case (op)
                OP_EXC, OP_IRQ: begin
                    redirect    <= 1'b1;
                    redirect_pc <= target;
                    ds_ack      <= ds_taken;
                    if (gen_entry) begin
                        if (!status_q[ST_EXL]) begin
                            epc_q          <= resume_pc;
                            cause_q[CA_BD] <= ds;
                        end
                        status_q[ST_EXL] <= 1'b1;
                        cause_q[CA_CODE_LO +: CODE_W] <= (op == OP_IRQ) ? '0 : code;
                    end else if (kind == EK_DEBUG) begin
                        depc_q     <= resume_pc;
                        debug_mode <= 1'b1;
                    end else begin
                        errorepc_q       <= resume_pc;
                        status_q[ST_ERL] <= 1'b1;
                        status_q[ST_BEV] <= 1'b1;
                        if (kind == EK_NMI) status_q[ST_NMI] <= 1'b1;
                        else                status_q[ST_SR]  <= 1'b1;
                    end
                end
                OP_ERET: begin
                    redirect    <= 1'b1;
                    redirect_pc <= target;
                    ll_clear    <= 1'b1;
                    if (status_q[ST_ERL]) status_q[ST_ERL] <= 1'b0;
                    else                  status_q[ST_EXL] <= 1'b0;
                end
                OP_DERET: begin
                    redirect    <= 1'b1;
                    redirect_pc <= target;
                    ll_clear    <= 1'b1;
                    debug_mode  <= 1'b0;
                end
                OP_STSWR: begin
                    status_q <= (sts_wdata & STATUS_WMASK) | (status_q & ~STATUS_WMASK);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trapseq_top.sv
// Exception entry and return sequencer. Takes one request per cycle and
// answers on the next edge with register updates and a redirect pulse.
// Assumes IRQ_W <= 8 (the mask and pending fields are bits 15:8).
module trapseq_top
    import trapseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    pc_in,
    input  logic             in_delay_slot,
    input  logic             exc_valid,
    input  logic [2:0]       exc_kind,
    input  logic [4:0]       exc_code,
    input  logic [IRQ_W-1:0] irq_lines,
    input  logic             eret,
    input  logic             deret,
    input  logic             sts_wr,
    input  logic [31:0]      sts_wdata,
    output logic             irq_take,
    output logic             redirect,
    output logic [AW-1:0]    redirect_pc,
    output logic             ds_ack,
    output logic             ll_clear,
    output logic [31:0]      status_q,
    output logic [31:0]      cause_q,
    output logic [AW-1:0]    epc_q,
    output logic [AW-1:0]    errorepc_q,
    output logic [AW-1:0]    depc_q,
    output logic             debug_mode
);

    op_e           op;
    exc_kind_e     kind;
    logic [AW-1:0] target;
    logic [AW-1:0] resume_pc;
    logic          gen_entry;
    logic          ds_taken;

    // Request kind as the package enumeration (kinds 5..7 act as general).
    always_comb begin
        kind = exc_kind_e'(exc_kind);
    end

    trapseq_arbiter #(.IRQ_W(IRQ_W)) i_arb (
        .exc_valid (exc_valid),
        .eret      (eret),
        .deret     (deret),
        .sts_wr    (sts_wr),
        .im        (status_q[ST_IM_LO +: IRQ_W]),
        .ip        (cause_q[CA_IP_LO +: IRQ_W]),
        .ie        (status_q[ST_IE]),
        .exl       (status_q[ST_EXL]),
        .erl       (status_q[ST_ERL]),
        .dbg       (debug_mode),
        .irq_take  (irq_take),
        .op        (op)
    );

    trapseq_target #(.AW(AW)) i_tgt (
        .op        (op),
        .kind      (kind),
        .exl       (status_q[ST_EXL]),
        .erl       (status_q[ST_ERL]),
        .bev       (status_q[ST_BEV]),
        .ds        (in_delay_slot),
        .pc        (pc_in),
        .epc       (epc_q),
        .errorepc  (errorepc_q),
        .depc      (depc_q),
        .target    (target),
        .resume_pc (resume_pc),
        .gen_entry (gen_entry),
        .ds_taken  (ds_taken)
    );

    trapseq_state #(.AW(AW), .IRQ_W(IRQ_W)) i_st (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .kind        (kind),
        .code        (exc_code),
        .irq_lines   (irq_lines),
        .sts_wdata   (sts_wdata),
        .target      (target),
        .resume_pc   (resume_pc),
        .gen_entry   (gen_entry),
        .ds_taken    (ds_taken),
        .ds          (in_delay_slot),
        .status_q    (status_q),
        .cause_q     (cause_q),
        .epc_q       (epc_q),
        .errorepc_q  (errorepc_q),
        .depc_q      (depc_q),
        .debug_mode  (debug_mode),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .ds_ack      (ds_ack),
        .ll_clear    (ll_clear)
    );

endmodule

// File: rtl/trapseq_checker.sv
// Cycle-by-cycle properties of the sequencer, bound onto the top module.
module trapseq_checker
    import trapseq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IRQ_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_valid,
    input logic [2:0]       exc_kind,
    input logic             eret,
    input logic             deret,
    input logic             irq_take,
    input logic [31:0]      status_q,
    input logic [31:0]      cause_q,
    input logic [AW-1:0]    epc_q,
    input logic [AW-1:0]    errorepc_q,
    input logic             debug_mode,
    input logic             redirect,
    input logic [AW-1:0]    redirect_pc,
    input logic             ds_ack
);

    assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (|(status_q[ST_IM_LO +: IRQ_W] & cause_q[CA_IP_LO +: IRQ_W])) &&
                     status_q[ST_IE] && !status_q[ST_EXL] && !status_q[ST_ERL] && !debug_mode);

    assert_nested_keeps_epc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && (exc_kind == 3'd0 || exc_kind == 3'd1) && status_q[ST_EXL])
        |=> ($stable(epc_q) && (cause_q[CA_BD] == $past(cause_q[CA_BD])) &&
             status_q[ST_EXL] && !ds_ack));

    assert_error_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind == 3'd2)
        |=> (status_q[ST_ERL] && status_q[ST_BEV] && status_q[ST_NMI] &&
             redirect && redirect_pc == AW'(VEC_RESET)));

    assert_debug_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_kind == 3'd4)
        |=> (debug_mode && redirect && redirect_pc == AW'(VEC_DEBUG)));

    assert_eret_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret && !exc_valid && !deret && status_q[ST_ERL])
        |=> (!status_q[ST_ERL] && redirect && redirect_pc == $past(errorepc_q)));

    assert_ack_with_redirect_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ds_ack |-> redirect);

endmodule

bind trapseq_top trapseq_checker #(.AW(AW), .IRQ_W(IRQ_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .exc_valid   (exc_valid),
    .exc_kind    (exc_kind),
    .eret        (eret),
    .deret       (deret),
    .irq_take    (irq_take),
    .status_q    (status_q),
    .cause_q     (cause_q),
    .epc_q       (epc_q),
    .errorepc_q  (errorepc_q),
    .debug_mode  (debug_mode),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .ds_ack      (ds_ack)
);

// File: tb/test_trapseq_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the step task drives one cycle of requests, updates a
// reference model and queues the expected redirect; a monitor pops it.
module test_trapseq_top;

    localparam logic [31:0] WMASK = 32'hF878_FF17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0;
    logic        in_delay_slot = 1'b0;
    logic        exc_valid = 1'b0;
    logic [2:0]  exc_kind = '0;
    logic [4:0]  exc_code = '0;
    logic [7:0]  irq_lines = '0;
    logic        eret = 1'b0;
    logic        deret = 1'b0;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic        irq_take, redirect, ds_ack, ll_clear, debug_mode;
    logic [31:0] redirect_pc, status_q, cause_q, epc_q, errorepc_q, depc_q;

    always #2.5 clk = ~clk;

    trapseq_top i_trapseq_top (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .in_delay_slot(in_delay_slot),
        .exc_valid(exc_valid), .exc_kind(exc_kind), .exc_code(exc_code),
        .irq_lines(irq_lines), .eret(eret), .deret(deret), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .irq_take(irq_take), .redirect(redirect),
        .redirect_pc(redirect_pc), .ds_ack(ds_ack), .ll_clear(ll_clear),
        .status_q(status_q), .cause_q(cause_q), .epc_q(epc_q),
        .errorepc_q(errorepc_q), .depc_q(depc_q), .debug_mode(debug_mode)
    );

    typedef struct {
        logic [31:0] pc;
        logic        ack;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    logic [31:0] m_status, m_cause, m_epc, m_err, m_depc;
    logic        m_dbg;

    task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got 0x%08h expected 0x%08h", req, what, got, exp);
        end
    endtask

    function automatic logic model_irq();
        return (|(m_status[15:8] & m_cause[15:8])) && m_status[0] &&
               !m_status[1] && !m_status[2] && !m_dbg;
    endfunction

    // Monitor: every redirect pulse must match the oldest queued item.
    always @(negedge clk) begin
        if (rst_n && redirect) begin
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R13 unexpected redirect: got 0x%08h expected none", redirect_pc);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (redirect_pc !== e.pc || ds_ack !== e.ack) begin
                    n_bad++;
                    $display("FAIL %s redirect: got 0x%08h ack %0b expected 0x%08h ack %0b",
                             e.req, redirect_pc, ds_ack, e.pc, e.ack);
                end
            end
        end
    end

    // Driver: one cycle of requests, reference update, then full compare.
    task automatic step(string req, bit ex, int kind, int code, bit er, bit der,
                        bit sw, logic [31:0] wd, logic [31:0] pc, bit ds);
        logic [31:0] rpc, base, epc_pc;
        bit          red, ack, ll;
        exp_t        e;
        red = 0; ack = 0; ll = 0; epc_pc = '0;
        rpc  = ds ? pc - 32'd4 : pc;
        base = m_status[22] ? 32'hBFC0_0200 : 32'h8000_0000;
        exc_valid = ex; exc_kind = 3'(kind); exc_code = 5'(code);
        eret = er; deret = der; sts_wr = sw; sts_wdata = wd;
        pc_in = pc; in_delay_slot = ds;
        if (ex) begin
            red = 1;
            if (kind == 2 || kind == 3) begin
                m_status = m_status | (kind == 2 ? 32'h0008_0000 : 32'h0010_0000) | 32'h0040_0004;
                m_err = rpc; epc_pc = 32'hBFC0_0000; ack = ds;
            end else if (kind == 4) begin
                m_depc = rpc; m_dbg = 1; epc_pc = 32'hBFC0_0480; ack = ds;
            end else begin
                epc_pc = base + ((kind == 1 && !m_status[1]) ? 32'h0 : 32'h180);
                if (!m_status[1]) begin m_epc = rpc; m_cause[31] = ds; ack = ds; end
                m_status[1] = 1'b1; m_cause[6:2] = 5'(code);
            end
        end else if (der) begin
            red = 1; ll = 1; epc_pc = m_depc; m_dbg = 0;
        end else if (er) begin
            red = 1; ll = 1;
            if (m_status[2]) begin epc_pc = m_err; m_status[2] = 1'b0; end
            else begin epc_pc = m_epc; m_status[1] = 1'b0; end
        end else if (model_irq()) begin
            red = 1; epc_pc = base + 32'h180;
            m_epc = rpc; m_cause[31] = ds; ack = ds;
            m_status[1] = 1'b1; m_cause[6:2] = 5'd0;
        end else if (sw) begin
            m_status = (wd & WMASK) | (m_status & ~WMASK);
        end
        m_cause[15:8] = irq_lines;
        if (red) begin
            e.pc = epc_pc; e.ack = ack; e.req = req;
            q.push_back(e);
        end
        @(negedge clk);
        exc_valid = 0; eret = 0; deret = 0; sts_wr = 0;
        check(req, "status", status_q, m_status);
        check(req, "cause", cause_q, m_cause);
        check(req, "epc", epc_q, m_epc);
        check(req, "errorepc", errorepc_q, m_err);
        check(req, "depc", depc_q, m_depc);
        check(req, "debug_mode", 32'(debug_mode), 32'(m_dbg));
        check(req, "ll_clear", 32'(ll_clear), 32'(ll));
        check(req, "redirect", 32'(redirect), 32'(red));
        check("R2", "irq_take", 32'(irq_take), 32'(model_irq()));
    endtask

    task automatic idle(string req, logic [31:0] pc);
        step(req, 0, 0, 0, 0, 0, 0, '0, pc, 0);
    endtask

    initial begin
        m_status = 32'h0040_0004; m_cause = '0; m_epc = '0; m_err = '0;
        m_depc = '0; m_dbg = 0;
        repeat (3) @(negedge clk);
        // R1: cold state is visible while still in reset and after release
        check("R1", "status", status_q, 32'h0040_0004);
        check("R1", "cause", cause_q, 32'h0);
        check("R1", "redirect_pc", redirect_pc, 32'hBFC0_0000);
        check("R1", "redirect", 32'(redirect), 32'h0);
        check("R1", "debug_mode", 32'(debug_mode), 32'h0);
        rst_n = 1'b1;
        check("R1", "irq_take", 32'(irq_take), 32'h0);

        // R3/R5: general entry with EXL clear, boot vectors
        step("R3", 1, 0, 10, 0, 0, 0, '0, 32'h0000_1000, 0);
        // R4: nested general entry keeps EPC and BD, no ack
        step("R4", 1, 0, 12, 0, 0, 0, '0, 32'h0000_2000, 1);
        // R6: refill with EXL set uses the normal offset
        step("R6", 1, 1, 2, 0, 0, 0, '0, 32'h0000_2100, 0);
        // R10: ERL set returns to errorepc, then EXL path returns to epc
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        // R5: clear BEV through a status write
        step("R5", 0, 0, 0, 0, 0, 1, 32'h0000_0000, 32'h0, 0);
        // R6/R12: refill load with EXL clear from a delay slot
        step("R6", 1, 1, 2, 0, 0, 0, '0, 32'h0000_3008, 1);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        step("R5", 1, 0, 4, 0, 0, 0, '0, 32'h0000_3100, 0);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        // R6/R7: refill store
        step("R7", 1, 1, 3, 0, 0, 0, '0, 32'h0000_4000, 0);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        // R8: NMI keeps existing Status bits
        step("R8", 0, 0, 0, 0, 0, 1, 32'h0000_FF01, 32'h0, 0);
        step("R8", 1, 2, 0, 0, 0, 0, '0, 32'h0000_5004, 1);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        // R8: soft reset
        step("R8", 1, 3, 0, 0, 0, 0, '0, 32'h0000_6000, 0);
        step("R10", 0, 0, 0, 1, 0, 0, '0, 32'h0, 0);
        // R9/R12: debug entry from a delay slot
        step("R9", 1, 4, 0, 0, 0, 0, '0, 32'h0000_7004, 1);
        // R2: pending enabled line is blocked by debug mode
        irq_lines = 8'h01;
        idle("R2", 32'h0000_8000);
        idle("R2", 32'h0000_8000);
        // R11: leave debug mode; interrupt then fires on the idle cycle
        step("R11", 0, 0, 0, 0, 1, 0, '0, 32'h0000_8000, 0);
        idle("R2", 32'h0000_8000);
        idle("R2", 32'h0000_8004);
        // R13: exception beats eret and status write
        step("R13", 1, 0, 8, 1, 0, 1, 32'h0, 32'h0000_9000, 0);
        // R13: deret beats eret
        step("R13", 0, 0, 0, 1, 1, 0, '0, 32'h0, 0);
        irq_lines = 8'h00;
        // R13: eret beats status write
        step("R13", 0, 0, 0, 1, 0, 1, 32'h0, 32'h0, 0);
        // R7: pending bits follow the lines, code and BD untouched
        step("R7", 0, 0, 0, 0, 0, 1, 32'h0040_FF00, 32'h0, 0);
        irq_lines = 8'hA5;
        idle("R7", 32'h0);
        idle("R7", 32'h0);
        irq_lines = 8'h00;
        idle("R7", 32'h0);
        repeat (2) @(negedge clk);
        check("R12", "pending redirects", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule